// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps the window pointer and the live-frame bitmap of a rotating register file with `NQUAD` groups of four physical registers. A sequencer presents one operation at a time: a call-entry that allocates a new frame, a windowed return that releases one, a relative rotate of the pointer, or a stack-move check that asks whether any of the three frames below the current one is live. The block decides each operation in a single cycle. It reports a success code or the precise exception, and it updates its own pointer and bitmap.

When a call-entry would land on a frame that is still live, the block raises a spill exception. Its kind (4, 8 or 12 registers) comes from scanning the bitmap. When a return finds that its target frame is not live, it raises a fill exception. Both cases report the old pointer and the faulting PC, and they flag that the exception-mode bit must be set. A legal call-entry also produces one register write: the new stack pointer for the callee frame. Moving register contents to or from memory is handled elsewhere.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer `win_base` is 0, the bitmap `win_start` is 16'h0001 (only quad 0 live), `done` is 0 and `exc_code` is 0.
- R2: `op_kind` selects the operation: 0 = call-entry, 1 = return, 2 = rotate, 3 = stack check. An operation strobed on `op_valid` gives `done` = 1 for exactly one cycle after the next clock edge, with `exc_code` 0 on success. Pointer and bitmap change only on a strobed operation. All pointer arithmetic wraps modulo `NQUAD`, and bitmap bit i belongs to quad i.
- R3: A call-entry is illegal (code 1) when `op_spec` > 3, when `ps_woe` is 0 or when `ps_excm` is 1. An illegal call-entry leaves pointer and bitmap unchanged and writes no register.
- R4: A legal call-entry that does not overflow pulses `wr_en` with `wr_idx` = `ps_callinc`*4 + `op_spec`[1:0] and `wr_data` = `op_sp` − `op_imm`*8. It advances the pointer by `ps_callinc` and sets the bitmap bit of the new pointer.
- R5: A call-entry overflows when any of the `ps_callinc` quads just above the pointer is live. Let n be one plus the distance from pointer+1 to the first live quad. The block then advances the pointer by n and leaves the bitmap unchanged. It reports `owb` = old pointer, `excm_set` = 1 and `epc_out` = `op_pc`, and writes no register.
- R6: The overflow kind comes from the distance d from pointer+1+n (old pointer) to the next live quad: d = 0 gives code 4, d = 1 gives code 5, and d ≥ 2 gives code 6.
- R7: A return takes its size n from `op_a0`[31:30]. m is 1, 2 or 3 for the nearest live quad at pointer−1, −2 or −3, and 0 when none of them is live. The return is illegal (code 1, no state change) when n = 0, when m ≠ 0 and m ≠ n, when `ps_woe` is 0 or when `ps_excm` is 1.
- R8: A legal return gives `ret_pc` = {`op_pc`[31:30], `op_a0`[29:0]} and moves the pointer back by n. If the new pointer's quad is live, the old pointer's bit is cleared and the code is 0.
- R9: If a legal return's target quad is not live, the pointer still moves back by n but the bitmap is unchanged. The code is 8, 9 or 10 for n = 1, 2 or 3, with `owb` = old pointer, `excm_set` = 1 and `epc_out` = `op_pc`.
- R10: Rotate adds the signed 4-bit value `op_imm`[3:0] to the pointer (wrapping) and leaves the bitmap unchanged.
- R11: Stack check gives code 2 when none of the quads at pointer−1, −2 and −3 is live and code 0 otherwise. It changes no state.
- R12: The bitmap is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | Operation select (R2) |
| op_spec | input | 4 | Register specifier of a call-entry |
| op_imm | input | 12 | Frame size of a call-entry, or rotate amount in bits [3:0] |
| op_sp | input | 32 | Current stack pointer value |
| op_a0 | input | 32 | Return-address register |
| op_pc | input | 32 | PC of the operation |
| ps_callinc | input | 2 | Caller increment |
| ps_woe | input | 1 | Window overflow enable |
| ps_excm | input | 1 | Exception mode bit |
| done | output | 1 | Completion pulse |
| exc_code | output | 4 | Outcome code |
| win_base | output | QW | Window pointer |
| win_start | output | NQUAD | Live-frame bitmap |
| owb | output | QW | Pointer saved by the last window exception |
| excm_set | output | 1 | Request to set the exception mode bit |
| epc_out | output | 32 | PC saved by the last window exception |
| ret_pc | output | 32 | Target of the last legal return |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Window-relative register index |
| wr_data | output | 32 | Register write data |

## Verification
The checker watches every cycle for the following. Each strobe produces a completion, and pointer and bitmap stay still between operations. An illegal outcome leaves the state alone. A successful call-entry leaves the new frame marked live. The exception-mode request appears only with a spill or fill code, and the saved pointer matches the pointer before the operation. The bitmap never empties. Only the bench scenarios can show that specific values come out right: the spill kind chosen from the bitmap scan, the distance rule on returns, the fill codes, the composed return PC and the write data. These scenarios walk the pointer around the wrap point and fill the bitmap with frames 1, 2 and 3 quads apart.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    OP_ENTRY  = 2'd0,
    OP_RETURN = 2'd1,
    OP_ROTATE = 2'd2,
    OP_STKCHK = 2'd3
  } rw_op_e;

  localparam logic [3:0] EXC_NONE    = 4'd0;
  localparam logic [3:0] EXC_ILLEGAL = 4'd1;
  localparam logic [3:0] EXC_ALLOCA  = 4'd2;
  localparam logic [3:0] EXC_OVF4    = 4'd4;
  localparam logic [3:0] EXC_OVF8    = 4'd5;
  localparam logic [3:0] EXC_OVF12   = 4'd6;
  localparam logic [3:0] EXC_UNF4    = 4'd8;
  localparam logic [3:0] EXC_UNF8    = 4'd9;
  localparam logic [3:0] EXC_UNF12   = 4'd10;

endpackage

// File: rtl/regwin_scan.sv
// Rotates the live-frame bitmap so that bit 0 is quad `start`, then counts
// trailing zeros of the rotated view.
module regwin_scan #(
  parameter int NQUAD = 16,
  localparam int QW = $clog2(NQUAD),
  localparam int CW = $clog2(NQUAD) + 1
) (
  input  logic [NQUAD-1:0] vec,
  input  logic [QW-1:0]    start,
  output logic [NQUAD-1:0] rotated,
  output logic [CW-1:0]    tz
);

  for (genvar g = 0; g < NQUAD; g++) begin : g_rot
    logic [QW-1:0] src;
    assign src        = start + QW'(g);
    assign rotated[g] = vec[src];
  end

  always_comb begin
    tz = CW'(NQUAD);
    for (int i = NQUAD - 1; i >= 0; i--) begin
      if (rotated[i]) tz = CW'(i);
    end
  end

endmodule

// File: rtl/regwin_entry.sv
// Call-entry decision: legality, spill detection, and the frame allocation.
module regwin_entry
  import regwin_pkg::*;
#(
  parameter int NQUAD = 16,
  parameter int XLEN  = 32,
  localparam int QW = $clog2(NQUAD),
  localparam int CW = $clog2(NQUAD) + 1
) (
  input  logic [NQUAD-1:0] ws,
  input  logic [QW-1:0]    wb,
  input  logic [1:0]       callinc,
  input  logic [3:0]       spec,
  input  logic             woe,
  input  logic             excm,
  input  logic [XLEN-1:0]  sp,
  input  logic [11:0]      imm,
  output logic             illegal,
  output logic             overflow,
  output logic [3:0]       ovf_code,
  output logic [QW-1:0]    next_wb,
  output logic [NQUAD-1:0] next_ws,
  output logic [3:0]       wr_idx,
  output logic [XLEN-1:0]  wr_data
);

  logic [QW-1:0]    above_start;
  logic [NQUAD-1:0] above_rot;
  logic [CW-1:0]    above_tz;
  logic [QW-1:0]    spill_step;
  logic [QW-1:0]    kind_start;
  logic [NQUAD-1:0] kind_rot;
  logic [CW-1:0]    kind_tz;
  logic [2:0]       ci_mask;
  logic [QW-1:0]    alloc_wb;

  assign above_start = wb + QW'(1);

  regwin_scan #(.NQUAD(NQUAD)) i_scan_above (
    .vec     (ws),
    .start   (above_start),
    .rotated (above_rot),
    .tz      (above_tz)
  );

  assign spill_step = QW'(above_tz) + QW'(1);
  assign kind_start = above_start + spill_step;

  regwin_scan #(.NQUAD(NQUAD)) i_scan_kind (
    .vec     (ws),
    .start   (kind_start),
    .rotated (kind_rot),
    .tz      (kind_tz)
  );

  always_comb begin
    case (callinc)
      2'd0:    ci_mask = 3'b000;
      2'd1:    ci_mask = 3'b001;
      2'd2:    ci_mask = 3'b011;
      default: ci_mask = 3'b111;
    endcase
  end

  assign illegal  = (spec > 4'd3) || !woe || excm;
  assign overflow = !illegal && ((above_rot[2:0] & ci_mask) != 3'b000);
  assign alloc_wb = wb + QW'(callinc);

  always_comb begin
    if (kind_tz == CW'(0))      ovf_code = EXC_OVF4;
    else if (kind_tz == CW'(1)) ovf_code = EXC_OVF8;
    else                        ovf_code = EXC_OVF12;
  end

  always_comb begin
    next_wb = wb;
    next_ws = ws;
    if (overflow) begin
      next_wb = wb + spill_step;
    end else if (!illegal) begin
      next_wb = alloc_wb;
      next_ws = ws | (NQUAD'(1) << alloc_wb);
    end
  end

  assign wr_idx  = {callinc, spec[1:0]};
  assign wr_data = sp - (XLEN'(imm) << 3);

endmodule

// File: rtl/regwin_return.sv
// Windowed return decision: legality, fill detection and frame release.
module regwin_return
  import regwin_pkg::*;
#(
  parameter int NQUAD = 16,
  parameter int XLEN  = 32,
  localparam int QW = $clog2(NQUAD)
) (
  input  logic [NQUAD-1:0] ws,
  input  logic [QW-1:0]    wb,
  input  logic [XLEN-1:0]  a0,
  input  logic [XLEN-1:0]  pc,
  input  logic             woe,
  input  logic             excm,
  output logic             illegal,
  output logic             underflow,
  output logic [3:0]       unf_code,
  output logic [QW-1:0]    next_wb,
  output logic [NQUAD-1:0] next_ws,
  output logic [XLEN-1:0]  ret_pc
);

  logic [1:0]    size_n;
  logic [1:0]    dist_m;
  logic [QW-1:0] back1, back2, back3;
  logic [QW-1:0] target_wb;
  logic          target_live;

  assign size_n = a0[XLEN-1 -: 2];
  assign back1  = wb - QW'(1);
  assign back2  = wb - QW'(2);
  assign back3  = wb - QW'(3);

  always_comb begin
    if (ws[back1])      dist_m = 2'd1;
    else if (ws[back2]) dist_m = 2'd2;
    else if (ws[back3]) dist_m = 2'd3;
    else                dist_m = 2'd0;
  end

  assign illegal = (size_n == 2'd0) ||
                   ((dist_m != 2'd0) && (dist_m != size_n)) ||
                   !woe || excm;

  assign target_wb   = wb - QW'(size_n);
  assign target_live = ws[target_wb];
  assign underflow   = !illegal && !target_live;
  assign unf_code    = {2'b10, size_n - 2'd1};
  assign ret_pc      = {pc[XLEN-1 -: 2], a0[XLEN-3:0]};

  always_comb begin
    next_wb = wb;
    next_ws = ws;
    if (!illegal) begin
      next_wb = target_wb;
      if (target_live) next_ws = ws & ~(NQUAD'(1) << wb);
    end
  end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NQUAD = 16,
  parameter int XLEN  = 32,
  localparam int QW = $clog2(NQUAD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic [3:0]       op_spec,
  input  logic [11:0]      op_imm,
  input  logic [XLEN-1:0]  op_sp,
  input  logic [XLEN-1:0]  op_a0,
  input  logic [XLEN-1:0]  op_pc,
  input  logic [1:0]       ps_callinc,
  input  logic             ps_woe,
  input  logic             ps_excm,
  output logic             done,
  output logic [3:0]       exc_code,
  output logic [QW-1:0]    win_base,
  output logic [NQUAD-1:0] win_start,
  output logic [QW-1:0]    owb,
  output logic             excm_set,
  output logic [XLEN-1:0]  epc_out,
  output logic [XLEN-1:0]  ret_pc,
  output logic             wr_en,
  output logic [3:0]       wr_idx,
  output logic [XLEN-1:0]  wr_data
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  logic [QW-1:0]    wb_q, wb_d;
  logic [NQUAD-1:0] ws_q, ws_d;
  logic             done_q, done_d;
  logic [3:0]       exc_q, exc_d;
  logic [QW-1:0]    owb_q, owb_d;
  logic             excm_q, excm_d;
  logic [XLEN-1:0]  epc_q, epc_d;
  logic [XLEN-1:0]  rpc_q, rpc_d;
  logic             wr_en_q, wr_en_d;
  logic [3:0]       wr_idx_q, wr_idx_d;
  logic [XLEN-1:0]  wr_data_q, wr_data_d;

  // call-entry path
  logic             en_illegal, en_ovf;
  logic [3:0]       en_code;
  logic [QW-1:0]    en_wb;
  logic [NQUAD-1:0] en_ws;
  logic [3:0]       en_idx;
  logic [XLEN-1:0]  en_data;

  regwin_entry #(.NQUAD(NQUAD), .XLEN(XLEN)) i_entry (
    .ws       (ws_q),
    .wb       (wb_q),
    .callinc  (ps_callinc),
    .spec     (op_spec),
    .woe      (ps_woe),
    .excm     (ps_excm),
    .sp       (op_sp),
    .imm      (op_imm),
    .illegal  (en_illegal),
    .overflow (en_ovf),
    .ovf_code (en_code),
    .next_wb  (en_wb),
    .next_ws  (en_ws),
    .wr_idx   (en_idx),
    .wr_data  (en_data)
  );

  // return path
  logic             rt_illegal, rt_unf;
  logic [3:0]       rt_code;
  logic [QW-1:0]    rt_wb;
  logic [NQUAD-1:0] rt_ws;
  logic [XLEN-1:0]  rt_pc;

  regwin_return #(.NQUAD(NQUAD), .XLEN(XLEN)) i_return (
    .ws        (ws_q),
    .wb        (wb_q),
    .a0        (op_a0),
    .pc        (op_pc),
    .woe       (ps_woe),
    .excm      (ps_excm),
    .illegal   (rt_illegal),
    .underflow (rt_unf),
    .unf_code  (rt_code),
    .next_wb   (rt_wb),
    .next_ws   (rt_ws),
    .ret_pc    (rt_pc)
  );

  // rotate and stack check
  logic [QW+3:0] rot_ext;
  logic [QW-1:0] rot_wb;
  logic          below_live;

  assign rot_ext    = {{QW{op_imm[3]}}, op_imm[3:0]};
  assign rot_wb     = wb_q + rot_ext[QW-1:0];
  assign below_live = ws_q[wb_q - QW'(1)] | ws_q[wb_q - QW'(2)] |
                      ws_q[wb_q - QW'(3)];

  // next state
  always_comb begin
    wb_d      = wb_q;
    ws_d      = ws_q;
    done_d    = 1'b0;
    exc_d     = exc_q;
    owb_d     = owb_q;
    excm_d    = 1'b0;
    epc_d     = epc_q;
    rpc_d     = rpc_q;
    wr_en_d   = 1'b0;
    wr_idx_d  = wr_idx_q;
    wr_data_d = wr_data_q;
    if (op_valid) begin
      done_d = 1'b1;
      exc_d  = EXC_NONE;
      case (rw_op_e'(op_kind))
        OP_ENTRY: begin
          wb_d = en_wb;
          ws_d = en_ws;
          if (en_illegal) begin
            exc_d = EXC_ILLEGAL;
          end else if (en_ovf) begin
            exc_d  = en_code;
            owb_d  = wb_q;
            excm_d = 1'b1;
            epc_d  = op_pc;
          end else begin
            wr_en_d   = 1'b1;
            wr_idx_d  = en_idx;
            wr_data_d = en_data;
          end
        end
        OP_RETURN: begin
          wb_d = rt_wb;
          ws_d = rt_ws;
          if (rt_illegal) begin
            exc_d = EXC_ILLEGAL;
          end else begin
            rpc_d = rt_pc;
            if (rt_unf) begin
              exc_d  = rt_code;
              owb_d  = wb_q;
              excm_d = 1'b1;
              epc_d  = op_pc;
            end
          end
        end
        OP_ROTATE: begin
          wb_d = rot_wb;
        end
        default: begin
          if (!below_live) exc_d = EXC_ALLOCA;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wb_q      <= '0;
      ws_q      <= NQUAD'(1);
      done_q    <= 1'b0;
      exc_q     <= EXC_NONE;
      owb_q     <= '0;
      excm_q    <= 1'b0;
      epc_q     <= '0;
      rpc_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      done_q  <= done_d;
      excm_q  <= excm_d;
      wr_en_q <= wr_en_d;
      if (op_valid) begin
        wb_q      <= wb_d;
        ws_q      <= ws_d;
        exc_q     <= exc_d;
        owb_q     <= owb_d;
        epc_q     <= epc_d;
        rpc_q     <= rpc_d;
        wr_idx_q  <= wr_idx_d;
        wr_data_q <= wr_data_d;
      end
    end
  end

  assign done      = done_q;
  assign exc_code  = exc_q;
  assign win_base  = wb_q;
  assign win_start = ws_q;
  assign owb       = owb_q;
  assign excm_set  = excm_q;
  assign epc_out   = epc_q;
  assign ret_pc    = rpc_q;
  assign wr_en     = wr_en_q;
  assign wr_idx    = wr_idx_q;
  assign wr_data   = wr_data_q;

endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk
  import regwin_pkg::*;
#(
  parameter int NQUAD = 16,
  localparam int QW = $clog2(NQUAD)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             done,
  input logic [3:0]       exc_code,
  input logic [QW-1:0]    win_base,
  input logic [NQUAD-1:0] win_start,
  input logic [QW-1:0]    owb,
  input logic             excm_set,
  input logic             wr_en
);

  logic win_exc;
  assign win_exc = (exc_code == EXC_OVF4) || (exc_code == EXC_OVF8) ||
                   (exc_code == EXC_OVF12) || (exc_code == EXC_UNF4) ||
                   (exc_code == EXC_UNF8) || (exc_code == EXC_UNF12);

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done); // R2

  AST_STATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(win_base) && $stable(win_start))); // R2

  AST_ILLEGAL_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc_code == EXC_ILLEGAL) |->
      (win_base == $past(win_base) && win_start == $past(win_start))); // R3

  AST_NEW_FRAME_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && exc_code == EXC_NONE && win_start[win_base])); // R4

  AST_EXCM_ONLY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    excm_set |-> (done && win_exc)); // R5

  AST_SAVED_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && win_exc) |-> (owb == $past(win_base))); // R9

  AST_BITMAP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    win_start != '0); // R12

endmodule

bind regwin_ctrl regwin_ctrl_chk #(.NQUAD(NQUAD)) i_regwin_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .done      (done),
  .exc_code  (exc_code),
  .win_base  (win_base),
  .win_start (win_start),
  .owb       (owb),
  .excm_set  (excm_set),
  .wr_en     (wr_en)
);

// File: tb/test_regwin_ctrl.sv
`timescale 1ns/1ps
module test_regwin_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [3:0]  op_spec = 4'd0;
  logic [11:0] op_imm = 12'd0;
  logic [31:0] op_sp = 32'd0, op_a0 = 32'd0, op_pc = 32'd0;
  logic [1:0]  ps_callinc = 2'd0;
  logic        ps_woe = 1'b1, ps_excm = 1'b0;
  logic        done, excm_set, wr_en;
  logic [3:0]  exc_code, win_base, owb, wr_idx;
  logic [15:0] win_start;
  logic [31:0] epc_out, ret_pc, wr_data;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  regwin_ctrl i_regwin_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_spec(op_spec), .op_imm(op_imm), .op_sp(op_sp), .op_a0(op_a0),
    .op_pc(op_pc), .ps_callinc(ps_callinc), .ps_woe(ps_woe),
    .ps_excm(ps_excm), .done(done), .exc_code(exc_code),
    .win_base(win_base), .win_start(win_start), .owb(owb),
    .excm_set(excm_set), .epc_out(epc_out), .ret_pc(ret_pc),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // strobe one op; on return the result registers are visible
  task automatic do_op(input logic [1:0] kind, input logic [3:0] spec,
                       input logic [11:0] imm, input logic [31:0] sp,
                       input logic [31:0] a0, input logic [31:0] pc);
    @(negedge clk);
    op_kind = kind; op_spec = spec; op_imm = imm;
    op_sp = sp; op_a0 = a0; op_pc = pc;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [3:0] code,
                              input logic [3:0] wb, input logic [15:0] ws);
    chk({req, " done"}, 32'(done), 32'd1);
    chk({req, " code"}, 32'(exc_code), 32'(code));
    chk({req, " base"}, 32'(win_base), 32'(wb));
    chk({req, " bitmap"}, 32'(win_start), 32'(ws));
  endtask

  task automatic t_reset_state();
    chk("R1 base", 32'(win_base), 32'd0);
    chk("R1 bitmap", 32'(win_start), 32'h0001);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 code", 32'(exc_code), 32'd0);
  endtask

  task automatic t_entry_illegal();
    ps_callinc = 2'd1; ps_woe = 1'b0; ps_excm = 1'b0;
    do_op(2'd0, 4'd1, 12'd2, 32'h1000, 0, 0);
    expect_state("R3 woe off", 4'd1, 4'd0, 16'h0001);
    chk("R3 no write", 32'(wr_en), 32'd0);
    ps_woe = 1'b1;
    do_op(2'd0, 4'd4, 12'd2, 32'h1000, 0, 0);
    expect_state("R3 spec>3", 4'd1, 4'd0, 16'h0001);
    ps_excm = 1'b1;
    do_op(2'd0, 4'd1, 12'd2, 32'h1000, 0, 0);
    expect_state("R3 excm", 4'd1, 4'd0, 16'h0001);
    ps_excm = 1'b0;
  endtask

  task automatic t_entry_ok();
    ps_callinc = 2'd1;
    do_op(2'd0, 4'd1, 12'd2, 32'h1000, 0, 0);
    expect_state("R4 ci1", 4'd0, 4'd1, 16'h0003);
    chk("R4 wr_en", 32'(wr_en), 32'd1);
    chk("R4 idx", 32'(wr_idx), 32'd5);
    chk("R4 data", wr_data, 32'h0FF0);
    @(negedge clk);
    chk("R2 done single", 32'(done), 32'd0);
    chk("R4 wr single", 32'(wr_en), 32'd0);
    ps_callinc = 2'd3;
    do_op(2'd0, 4'd2, 12'h0FF, 32'h2000, 0, 0);
    expect_state("R4 ci3", 4'd0, 4'd4, 16'h0013);
    chk("R4 idx ci3", 32'(wr_idx), 32'd14);
    chk("R4 data ci3", wr_data, 32'h1808);
  endtask

  task automatic t_rotate_stack();
    do_op(2'd3, 0, 0, 0, 0, 0);
    expect_state("R11 live below", 4'd0, 4'd4, 16'h0013);
    do_op(2'd2, 0, 12'd2, 0, 0, 0);
    expect_state("R10 +2", 4'd0, 4'd6, 16'h0013);
    do_op(2'd3, 0, 0, 0, 0, 0);
    expect_state("R11 at dist 2", 4'd0, 4'd6, 16'h0013);
    do_op(2'd2, 0, 12'd3, 0, 0, 0);
    expect_state("R10 +3", 4'd0, 4'd9, 16'h0013);
    do_op(2'd3, 0, 0, 0, 0, 0);
    expect_state("R11 alloca", 4'd2, 4'd9, 16'h0013);
    do_op(2'd2, 0, 12'h00B, 0, 0, 0);
    expect_state("R10 -5", 4'd0, 4'd4, 16'h0013);
  endtask

  task automatic t_return();
    do_op(2'd1, 0, 0, 0, 32'hC000_0500, 32'h8000_1234);
    expect_state("R8 n3", 4'd0, 4'd1, 16'h0003);
    chk("R8 ret pc", ret_pc, 32'h8000_0500);
    chk("R8 no excm", 32'(excm_set), 32'd0);
    do_op(2'd1, 0, 0, 0, 32'h8000_0000, 32'h0);
    expect_state("R7 m!=n", 4'd1, 4'd1, 16'h0003);
    do_op(2'd1, 0, 0, 0, 32'h0000_0100, 32'h0);
    expect_state("R7 n0", 4'd1, 4'd1, 16'h0003);
    ps_woe = 1'b0;
    do_op(2'd1, 0, 0, 0, 32'h4000_0010, 32'h0);
    expect_state("R7 woe off", 4'd1, 4'd1, 16'h0003);
    ps_woe = 1'b1;
    do_op(2'd1, 0, 0, 0, 32'h4000_0010, 32'h0000_0040);
    expect_state("R8 n1", 4'd0, 4'd0, 16'h0001);
    chk("R8 ret pc n1", ret_pc, 32'h0000_0010);
  endtask

  task automatic t_underflow();
    do_op(2'd1, 0, 0, 0, 32'h4000_0000, 32'h1111_0000);
    expect_state("R9 unf4", 4'd8, 4'd15, 16'h0001);
    chk("R9 owb", 32'(owb), 32'd0);
    chk("R9 excm", 32'(excm_set), 32'd1);
    chk("R9 epc", epc_out, 32'h1111_0000);
    do_op(2'd2, 0, 12'd1, 0, 0, 0);
    expect_state("R10 wrap +1", 4'd0, 4'd0, 16'h0001);
    chk("R10 no excm", 32'(excm_set), 32'd0);
    do_op(2'd1, 0, 0, 0, 32'h8000_0000, 32'h2222_0000);
    expect_state("R9 unf8", 4'd9, 4'd14, 16'h0001);
    do_op(2'd2, 0, 12'd2, 0, 0, 0);
    do_op(2'd1, 0, 0, 0, 32'hC000_0000, 32'h3333_0000);
    expect_state("R9 unf12", 4'd10, 4'd13, 16'h0001);
    chk("R9 epc 12", epc_out, 32'h3333_0000);
  endtask

  task automatic t_overflow12();
    do_reset();
    ps_callinc = 2'd3;
    for (int i = 0; i < 5; i++) do_op(2'd0, 4'd1, 12'd0, 32'h100, 0, 0);
    expect_state("R4 five frames", 4'd0, 4'd15, 16'h9249);
    do_op(2'd0, 4'd1, 12'd0, 32'h100, 0, 32'hABCD_0000);
    expect_state("R6 ovf12", 4'd6, 4'd0, 16'h9249);
    chk("R5 owb", 32'(owb), 32'd15);
    chk("R5 excm", 32'(excm_set), 32'd1);
    chk("R5 epc", epc_out, 32'hABCD_0000);
    chk("R5 no write", 32'(wr_en), 32'd0);
  endtask

  task automatic t_overflow4();
    do_reset();
    ps_callinc = 2'd1;
    for (int i = 0; i < 15; i++) do_op(2'd0, 4'd0, 12'd0, 32'h100, 0, 0);
    expect_state("R4 full", 4'd0, 4'd15, 16'hFFFF);
    do_op(2'd0, 4'd0, 12'd0, 32'h100, 0, 32'h5);
    expect_state("R6 ovf4", 4'd4, 4'd0, 16'hFFFF);
    chk("R5 owb 4", 32'(owb), 32'd15);
  endtask

  task automatic t_overflow8();
    do_reset();
    ps_callinc = 2'd2;
    for (int i = 0; i < 7; i++) do_op(2'd0, 4'd0, 12'd0, 32'h100, 0, 0);
    expect_state("R4 even frames", 4'd0, 4'd14, 16'h5555);
    do_op(2'd0, 4'd0, 12'd0, 32'h100, 0, 32'h9);
    expect_state("R6 ovf8", 4'd5, 4'd0, 16'h5555);
    chk("R5 owb 8", 32'(owb), 32'd14);
    chk("R12 bitmap kept", 32'(win_start != 16'h0), 32'd1);
  endtask

  logic finished = 1'b0;

  initial begin
    do_reset();
    t_reset_state();
    t_entry_illegal();
    t_entry_ok();
    t_rotate_stack();
    t_return();
    t_underflow();
    t_overflow12();
    t_overflow4();
    t_overflow8();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule